// File: doc/BRIEF.md
# Four-Lane Comma-Aligned Deskew Buffer

The block receives four byte-wide receive lanes that have already been decoded. Each lane write carries a data byte, a K-character flag, a comma flag and an error flag. Each lane writes its byte and its three flags as one entry into its own 8-entry FIFO. The four lanes can reach the block with different latencies. The block removes that skew, so that bytes which were sent on the same cycle leave the block on the same output cycle.

A lane word that has both the K flag and the comma flag set is a K28.5 alignment marker. When `align_en` rises, the block hunts for the marker on each lane. On every lane it discards the words that come ahead of the marker. Each lane that already holds its marker at the head of its FIFO waits for the other lanes. When all four heads are markers, the block releases the four markers together and raises `deskew_done`. From then on the lanes advance in lockstep, and later markers pass through like ordinary data.

The block reports an alignment failure in one case. A lane may hold its marker at the head of its FIFO while its occupancy grows beyond the skew window and some other lane still has no marker. The block then raises `skew_error` and aligns nothing. While `align_en` is low, each lane passes its words straight through on its own valid bit. The error flags of each lane stay separate in every mode. Dropping `align_en` returns the block to that unaligned pass-through.

Top module: `lane_deskew`

## Requirements
- R1: The data byte, K flag, comma flag and error flag of a lane word are stored as one entry and leave the block on the same output cycle. Lane l occupies bits [8l+7:8l] of the data buses and bit l of the flag and valid buses.
- R2: While reset (`rst_n` low) is held, and right after it, `out_valid`, `deskew_done` and `skew_error` are 0, the output buses are 0 and all FIFOs are empty.
- R3: While `align_en` is 0, a word written on lane l at one clock edge is presented at the next edge, with only `out_valid[l]` set for it.
- R4: While hunting, a lane discards the words that come ahead of its marker (K flag = 1 and comma flag = 1). `deskew_done` stays 0 until all four markers are aligned. The first aligned output is the markers themselves.
- R5: When every lane holds a marker at its FIFO head, all four markers leave on one cycle with `out_valid` = 4'b1111. `deskew_done` rises on that same edge.
- R6: After alignment, `out_valid` is either 4'b0000 or 4'b1111. Words with the same send index leave together, in order, with no slip or loss. This holds for repeated back-to-back markers and for later markers.
- R7: The lanes align when their marker arrival times differ by at most 4 words. `skew_error` rises, and alignment does not happen, when a lane holding its marker at the head reaches 5 or more stored entries while some other lane has no marker at its head.
- R8: The error flag of each lane comes out on that lane's own output bit, unchanged by the other lanes, both in pass-through and after alignment.
- R9: Driving `align_en` low clears `deskew_done` and `skew_error` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for writes, reads and control |
| rst_n | input | 1 | Active-low synchronous reset |
| align_en | input | 1 | High: hunt for markers and lock the lanes; low: unaligned pass-through |
| in_valid | input | 4 | Per-lane write strobe |
| in_data | input | 32 | Per-lane data bytes |
| in_kflag | input | 4 | Per-lane K-character flag |
| in_comma | input | 4 | Per-lane comma flag |
| in_err | input | 4 | Per-lane decode error flag |
| out_valid | output | 4 | Per-lane output valid |
| out_data | output | 32 | Per-lane output bytes |
| out_kflag | output | 4 | Per-lane output K flag |
| out_comma | output | 4 | Per-lane output comma flag |
| out_err | output | 4 | Per-lane output error flag |
| deskew_done | output | 1 | Lanes are aligned and advancing in lockstep |
| skew_error | output | 1 | Marker skew exceeded the window; held until `align_en` drops |

## Verification
The bench targets the skew window boundary, where a skew of 4 words must lock and a skew of 5 must fail. A design with an off-by-one in the occupancy test either misses the error or fails a legal skew. Streams that carry four back-to-back markers and a later stray marker are compared word by word with the sent index. A design that realigned on a later marker would slip one lane and break the comparison. The bench also checks that the first aligned cycle carries four markers in the same cycle that `deskew_done` rises. A design that registered the alignment decision one cycle late would emit a partial or pre-marker word there. Per-lane error bits are checked against a per-lane hash, which catches error flags that are swapped between lanes or merged.

// File: rtl/lane_deskew_pkg.sv
package lane_deskew_pkg;

   // flags that travel beside every data byte
   typedef struct packed {
      logic kchar;
      logic comma;
      logic err;
   } tag_t;

   localparam int TAG_W = $bits(tag_t);

   // a K28.5 alignment marker carries both flags
   function automatic logic is_marker(tag_t t);
      return t.kchar & t.comma;
   endfunction

endpackage

// File: rtl/lane_fifo.sv
module lane_fifo
   import lane_deskew_pkg::*;
#(
   parameter int DW    = 8,
   parameter int DEPTH = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  tag_t          wr_tag,
   input  logic          rd_en,
   output logic [DW-1:0] head_data,
   output tag_t          head_tag,
   output logic [CW-1:0] fill
);

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("lane_fifo: DEPTH must be a power of two");
   end

   logic [DW-1:0] dmem [DEPTH];
   tag_t          tmem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic          accept;

   assign accept    = wr_en && ((fill != CW'(DEPTH)) || rd_en);
   assign head_data = dmem[rptr];
   assign head_tag  = tmem[rptr];

   always_ff @(posedge clk) begin
      if (accept) begin
         dmem[wptr] <= wr_data;
         tmem[wptr] <= wr_tag;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         fill <= '0;
      end else begin
         if (accept) wptr <= wptr + 1'b1;
         if (rd_en)  rptr <= rptr + 1'b1;
         fill <= fill + CW'(accept) - CW'(rd_en);
      end
   end

   // R1: the controller only pops entries that exist
   a_r1_pop_has_entry: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> fill != '0);

   // R2: occupancy never passes the depth
   a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CW'(DEPTH));

endmodule

// File: rtl/align_ctrl.sv
module align_ctrl #(
   parameter int LANES    = 4,
   parameter int CW       = 4,
   parameter int MAX_SKEW = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      align_en,
   input  logic [LANES-1:0]          marker,
   input  logic [LANES-1:0]          filled,
   input  logic [LANES-1:0][CW-1:0]  counts,
   output logic [LANES-1:0]          pop,
   output logic                      done,
   output logic                      skew_err
);

   logic [LANES-1:0] far;
   logic             all_mark;
   logic             hunting;

   for (genvar g = 0; g < LANES; g++) begin : g_far
      assign far[g] = marker[g] & filled[g] & (counts[g] > CW'(MAX_SKEW));
   end

   always_comb begin
      all_mark = &(marker & filled);
      hunting  = align_en & ~done & ~skew_err;
      if (!align_en || skew_err)
         pop = filled;
      else if (done)
         pop = (&filled) ? '1 : '0;
      else if (all_mark)
         pop = '1;
      else
         pop = filled & ~marker;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !align_en) begin
         done     <= 1'b0;
         skew_err <= 1'b0;
      end else begin
         if (hunting && all_mark)
            done <= 1'b1;
         if (hunting && !all_mark && (|far))
            skew_err <= 1'b1;
      end
   end

   // R7: a failed alignment never reports lock
   a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && skew_err));

   // R9: releasing align_en clears both status bits
   a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
      !align_en |=> !done && !skew_err);

endmodule

// File: rtl/lane_deskew.sv
module lane_deskew
   import lane_deskew_pkg::*;
#(
   parameter int LANES    = 4,
   parameter int DW       = 8,
   parameter int DEPTH    = 8,
   parameter int MAX_SKEW = 4,
   localparam int CW      = $clog2(DEPTH + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  align_en,
   input  logic [LANES-1:0]      in_valid,
   input  logic [LANES*DW-1:0]   in_data,
   input  logic [LANES-1:0]      in_kflag,
   input  logic [LANES-1:0]      in_comma,
   input  logic [LANES-1:0]      in_err,
   output logic [LANES-1:0]      out_valid,
   output logic [LANES*DW-1:0]   out_data,
   output logic [LANES-1:0]      out_kflag,
   output logic [LANES-1:0]      out_comma,
   output logic [LANES-1:0]      out_err,
   output logic                  deskew_done,
   output logic                  skew_error
);

   if (MAX_SKEW >= DEPTH || MAX_SKEW < 1) begin : g_bad_skew
      $error("lane_deskew: MAX_SKEW must lie in 1..DEPTH-1");
   end
   if (LANES < 2) begin : g_bad_lanes
      $error("lane_deskew: at least two lanes are needed");
   end

   logic [LANES-1:0][DW-1:0] hd;
   tag_t                     ht [LANES];
   logic [LANES-1:0][CW-1:0] cnt;
   logic [LANES-1:0]         mark, filled, pop;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      tag_t wtag;
      assign wtag      = '{kchar: in_kflag[g], comma: in_comma[g], err: in_err[g]};
      assign mark[g]   = is_marker(ht[g]);
      assign filled[g] = cnt[g] != '0;

      lane_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (in_valid[g]),
         .wr_data  (in_data[g*DW +: DW]),
         .wr_tag   (wtag),
         .rd_en    (pop[g]),
         .head_data(hd[g]),
         .head_tag (ht[g]),
         .fill     (cnt[g])
      );
   end

   align_ctrl #(.LANES(LANES), .CW(CW), .MAX_SKEW(MAX_SKEW)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .align_en(align_en),
      .marker  (mark),
      .filled  (filled),
      .counts  (cnt),
      .pop     (pop),
      .done    (deskew_done),
      .skew_err(skew_error)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= '0;
         out_data  <= '0;
         out_kflag <= '0;
         out_comma <= '0;
         out_err   <= '0;
      end else begin
         out_valid <= pop;
         for (int l = 0; l < LANES; l++) begin
            if (pop[l]) begin
               out_data[l*DW +: DW] <= hd[l];
               out_kflag[l]         <= ht[l].kchar;
               out_comma[l]         <= ht[l].comma;
               out_err[l]           <= ht[l].err;
            end
         end
      end
   end

   // R5: lock is declared on the very cycle the four markers leave
   a_r5_markers_together: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(deskew_done) |-> (&out_valid) && (&out_kflag) && (&out_comma));

   // R6: once locked, lanes never advance one at a time
   a_r6_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
      (deskew_done && $past(deskew_done)) |-> (out_valid == '0 || (&out_valid)));

endmodule

// File: tb/sim_lane_deskew.sv
module sim_lane_deskew;

   localparam int LN    = 4;
   localparam int LEN   = 24;
   localparam int FIRST = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          align_en = 1'b0;
   logic [3:0]    in_valid = '0;
   logic [31:0]   in_data = '0;
   logic [3:0]    in_kflag = '0, in_comma = '0, in_err = '0;
   logic [3:0]    out_valid;
   logic [31:0]   out_data;
   logic [3:0]    out_kflag, out_comma, out_err;
   logic          deskew_done, skew_error;

   int total = 0;
   int bad   = 0;
   int unsigned salt;

   always #2 clk = ~clk;

   lane_deskew u0 (
      .clk(clk), .rst_n(rst_n), .align_en(align_en),
      .in_valid(in_valid), .in_data(in_data), .in_kflag(in_kflag),
      .in_comma(in_comma), .in_err(in_err),
      .out_valid(out_valid), .out_data(out_data), .out_kflag(out_kflag),
      .out_comma(out_comma), .out_err(out_err),
      .deskew_done(deskew_done), .skew_error(skew_error)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   function automatic bit is_mark_idx(int n);
      return (n >= FIRST && n <= FIRST + 3) || n == 12;
   endfunction

   // word = {k, comma, err, data}
   function automatic logic [10:0] mk(int n, int lane);
      logic [7:0] h;
      h = 8'((n * 29 + lane * 53 + int'(salt)) ^ (n * lane));
      if (is_mark_idx(n)) return {1'b1, 1'b1, 1'b0, 8'hBC};
      return {h[2], 1'b0, h[5], 8'((n * 37) ^ (lane * 91) ^ int'(salt))};
   endfunction

   task automatic drive_idle();
      in_valid = '0; in_kflag = '0; in_comma = '0; in_err = '0;
   endtask

   task automatic run_stream(input int s0, input int s1, input int s2, input int s3, input bit expect_ok);
      int sk[4];
      int mx;
      int expn;
      bit seen;
      bit prevd;
      sk = '{s0, s1, s2, s3};
      mx = 0;
      for (int l = 0; l < LN; l++) if (sk[l] > mx) mx = sk[l];
      salt = $urandom;
      align_en = 1'b1;
      @(negedge clk);
      expn = FIRST; seen = 1'b0; prevd = deskew_done;
      for (int t = 0; t < LEN + mx + 10; t++) begin
         if (deskew_done && out_valid == 4'hF) begin
            if (!expect_ok) begin
               chk(1'b0, "R7 locked despite excess skew", 64'(out_valid), 64'h0);
            end else begin
               if (!seen) begin
                  chk(!prevd, "R5 done rises with first aligned word", 64'(prevd), 64'h0);
                  chk(&(out_kflag & out_comma), "R4 first aligned word is marker",
                      64'({out_kflag, out_comma}), 64'hFF);
                  seen = 1'b1;
               end
               begin
                  logic [43:0] got, exp;
                  for (int l = 0; l < LN; l++) begin
                     logic [10:0] w;
                     w = mk(expn, l);
                     exp[l*11 +: 11] = w;
                     got[l*11 +: 11] = {out_kflag[l], out_comma[l], out_err[l], out_data[l*8 +: 8]};
                  end
                  chk(got == exp, "R6/R1/R8 aligned lane words", 64'(got), 64'(exp));
               end
               expn++;
            end
         end else if (deskew_done && out_valid != 4'h0) begin
            chk(1'b0, "R6 partial output while locked", 64'(out_valid), 64'hF);
         end
         prevd = deskew_done;
         for (int l = 0; l < LN; l++) begin
            int idx;
            logic [10:0] w;
            idx = t - sk[l];
            if (idx >= 0 && idx < LEN) begin
               w = mk(idx, l);
               in_valid[l] = 1'b1;
               {in_kflag[l], in_comma[l], in_err[l], in_data[l*8 +: 8]} = w;
            end else begin
               in_valid[l] = 1'b0;
            end
         end
         @(negedge clk);
      end
      drive_idle();
      if (expect_ok) begin
         chk(expn == LEN, "R6 all aligned words delivered", 64'(expn), 64'(LEN));
         chk(deskew_done && !skew_error, "R7 skew within window locks",
             64'({deskew_done, skew_error}), 64'h2);
      end else begin
         chk(!deskew_done && skew_error, "R7 excess skew flagged",
             64'({deskew_done, skew_error}), 64'h1);
      end
      align_en = 1'b0;
      @(negedge clk);
      chk(!deskew_done && !skew_error, "R9 release clears status",
          64'({deskew_done, skew_error}), 64'h0);
      repeat (12) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      salt = $urandom(32'd2024);
      repeat (3) @(negedge clk);
      // R2: reset state
      chk(out_valid == 0 && out_data == 0 && !deskew_done && !skew_error,
          "R2 reset outputs", 64'({out_valid, out_data, deskew_done, skew_error}), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 0 && !deskew_done && !skew_error, "R2 after reset",
          64'({out_valid, deskew_done, skew_error}), 64'h0);

      // R3/R8: unaligned pass-through on one lane with its error flag
      in_valid = 4'b0100; in_data = 32'h00A5_0000; in_err = 4'b0100;
      @(negedge clk);
      drive_idle();
      chk(out_valid == 4'b0000, "R3 no output before next edge", 64'(out_valid), 64'h0);
      @(negedge clk);
      chk(out_valid == 4'b0100 && out_data[23:16] == 8'hA5,
          "R3 pass-through lane2", 64'({out_valid, out_data[23:16]}), 64'h4A5);
      chk(out_err == 4'b0100, "R8 error stays on lane2", 64'(out_err), 64'h4);
      @(negedge clk);
      chk(out_valid == 4'b0000, "R3 single word only", 64'(out_valid), 64'h0);

      // directed corners
      run_stream(0, 0, 0, 0, 1'b1);
      run_stream(4, 0, 0, 0, 1'b1);   // R7 boundary: 4 words locks
      run_stream(0, 2, 4, 1, 1'b1);
      run_stream(0, 0, 5, 0, 1'b0);   // R7 boundary: 5 words fails
      run_stream(1, 8, 2, 3, 1'b0);

      // random skews inside the window
      for (int r = 0; r < 8; r++) begin
         run_stream(int'($urandom % 5), int'($urandom % 5),
                    int'($urandom % 5), int'($urandom % 5), 1'b1);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule